// File: doc/BRIEF.md
# Commit-Stage Squash and Trap Controller

This block manages recovery for a single hardware thread at the retirement end of an out-of-order pipeline. It decides, once per cycle, whether the reorder buffer must be flushed and with which boundary: every entry younger than the boundary sequence number is discarded. Three causes can order a flush. An execute-stage redirect carries its own sequence number. A trap is raised a fixed delay after a fault reaches the buffer head. A context-change request arrives from outside the pipeline.

Execute-stage redirects are filtered by age. The block keeps the youngest sequence number that is still valid, which is updated by insertions and lowered by every accepted flush, so a late request from a younger instruction cannot undo a flush already issued for an older one. A fault reported by fetch is parked rather than taken at once. It becomes a trap only after the buffer has drained, a minimum wait has elapsed and no stores remain to be written back. A matching clear signal cancels the parked fault.

Top module: `squash_trap_ctrl`

## Requirements
- R1: A head fault seen while the status is Running (0) moves the status to TrapPending (2). The trap flush request becomes pending TRAP_DLY (default 6) clock edges later, and the squash pulse appears on the following edge, TRAP_DLY+1 edges after the edge that sampled the fault. No squash pulse appears before that edge unless another cause orders one.
- R2: When a trap flush request and a context-change request are pending in the same cycle, the trap flush is issued first (cause code 1) and the context flush (cause code 2) follows on the next cycle.
- R3: A trap or context flush uses a boundary of head sequence minus one. The boundary is 0 when the buffer is empty or the head sequence is 0. Such a flush also resets the youngest-valid register to 0, so a later execute request with a sequence number above 0 is rejected until new insertions arrive. The redirect output takes the commit PC.
- R4: An execute-stage request (cause code 0) is accepted only when the status is not TrapPending and its sequence number is unsigned less than or equal to the youngest-valid register. Otherwise it produces no squash pulse and leaves the status unchanged.
- R5: With the include-self flag set, the accepted boundary is the request sequence minus one, saturating at 0. The boundary becomes the new youngest-valid value. The redirect output takes the request's PC.
- R6: Every accepted flush produces a squash pulse exactly one cycle wide on the edge after the decision, with the boundary, cause and redirect PC valid alongside. The status becomes ROBSquashing (1) and robSquashing stays high until the buffer reports done-squashing, after which the status is Running.
- R7: A fetch fault seen while Running moves the status to FetchTrapPending (3) and starts a FETCH_DLY-cycle (default 12) deadline. A clear-fault signal while FetchTrapPending returns the status to Running on the next edge.
- R8: A parked fetch fault is taken on the first cycle in which the buffer is empty, the deadline has expired and no stores are pending: the status becomes TrapPending and the trap squash pulse follows one edge later, FETCH_DLY+2 edges after the fault was sampled at the earliest. While stores are pending the status stays FetchTrapPending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid_i | input | 1 | A new instruction entered the buffer this cycle |
| ins_seq_i | input | SEQ_W | Sequence number of that instruction |
| ex_squash_i | input | 1 | Execute-stage flush request |
| ex_seq_i | input | SEQ_W | Sequence number of the requesting instruction |
| ex_incl_self_i | input | 1 | Flush the requesting instruction as well |
| ex_pc_i | input | PC_W | Redirect target of the execute request |
| head_fault_i | input | 1 | Fault present at the buffer head |
| ctx_squash_i | input | 1 | Context-change flush request |
| fetch_fault_i | input | 1 | Fault reported by fetch |
| fetch_clear_i | input | 1 | Withdraw the fetch fault |
| rob_empty_i | input | 1 | Buffer holds no entries for this thread |
| rob_sq_done_i | input | 1 | Buffer has finished discarding entries |
| stores_pend_i | input | 1 | Stores still awaiting write-back |
| head_seq_i | input | SEQ_W | Sequence number at the buffer head |
| commit_pc_i | input | PC_W | PC of the next instruction to commit |
| squash_o | output | 1 | One-cycle flush command |
| squash_seq_o | output | SEQ_W | Flush boundary; younger entries are discarded |
| squash_cause_o | output | 2 | 0 execute, 1 trap, 2 context change |
| redirect_pc_o | output | PC_W | Fetch restart address |
| rob_squashing_o | output | 1 | Buffer flush in progress |
| status_o | output | 2 | 0 Running, 1 ROBSquashing, 2 TrapPending, 3 FetchTrapPending |

## Verification
On every cycle the assertions check the following. Every squash pulse coincides with the ROBSquashing status. No pulse appears during TrapPending unless a flush request is pending. TrapPending is always backed by a running trap timer or a pending request. Leaving FetchTrapPending for TrapPending happens only with an empty buffer and no pending stores. The youngest-valid register never rises on an accepted execute flush. Exact delays need the bench's directed scenarios: the edge on which a trap fires after a head fault, and the earliest edge for a parked fetch fault. The scenarios also cover trap-before-context ordering, boundary arithmetic with and without include-self, and rejection by age after a trap reset.

// File: rtl/sqc_pkg.sv
package sqc_pkg;

  typedef enum logic [1:0] {
    ST_RUNNING  = 2'd0,
    ST_ROB_SQ   = 2'd1,
    ST_TRAP     = 2'd2,
    ST_FETCH    = 2'd3
  } sqc_status_e;

  typedef enum logic [1:0] {
    CAUSE_EXEC = 2'd0,
    CAUSE_TRAP = 2'd1,
    CAUSE_CTX  = 2'd2
  } sqc_cause_e;

endpackage

// File: rtl/sqc_delay_timer.sv
module sqc_delay_timer #(
  parameter int DLY   = 6,
  parameter bit LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic cancel_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (cancel_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (load_i) begin
      cnt_d  = CW'(DLY);
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - CW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  generate
    if (LEVEL) begin : g_level
      logic armed_q, armed_d, armed_en;
      always_comb begin
        armed_d  = armed_q;
        armed_en = cancel_i | load_i;
        if (cancel_i)    armed_d = 1'b0;
        else if (load_i) armed_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        armed_q <= 1'b0;
        else if (armed_en) armed_q <= armed_d;
      end
      assign done_o = armed_q && (cnt_q == '0);

      // R8: once expired, the deadline stays expired until re-armed or cancelled
      deadline_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cancel_i && !load_i) |=> done_o);
    end else begin : g_pulse
      assign done_o = (cnt_q == CW'(1));

      // R1: the trap timer fires for a single cycle per start
      fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> !done_o);
    end
  endgenerate

endmodule

// File: rtl/sqc_age_filter.sv
module sqc_age_filter #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid_i,
  input  logic [SEQ_W-1:0] ins_seq_i,
  input  logic             req_i,
  input  logic [SEQ_W-1:0] req_seq_i,
  input  logic             incl_self_i,
  input  logic             block_i,
  input  logic             clear_i,
  output logic             accept_o,
  output logic [SEQ_W-1:0] bound_o
);
  logic [SEQ_W-1:0] young_q, young_d;
  logic             young_en;

  always_comb begin
    accept_o = req_i && !block_i && (req_seq_i <= young_q);
    if (incl_self_i && (req_seq_i != '0)) bound_o = req_seq_i - SEQ_W'(1);
    else                                  bound_o = req_seq_i;
  end

  always_comb begin
    young_d  = young_q;
    young_en = 1'b1;
    if (clear_i)          young_d = '0;
    else if (accept_o)    young_d = bound_o;
    else if (ins_valid_i) young_d = ins_seq_i;
    else                  young_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        young_q <= '0;
    else if (young_en) young_q <= young_d;
  end

  // R5: an accepted execute flush never raises the youngest-valid value
  young_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && !clear_i) |=> (young_q <= $past(young_q)));

endmodule

// File: rtl/squash_trap_ctrl.sv
module squash_trap_ctrl
  import sqc_pkg::*;
#(
  parameter int SEQ_W     = 16,
  parameter int PC_W      = 32,
  parameter int TRAP_DLY  = 6,
  parameter int FETCH_DLY = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid_i,
  input  logic [SEQ_W-1:0] ins_seq_i,
  input  logic             ex_squash_i,
  input  logic [SEQ_W-1:0] ex_seq_i,
  input  logic             ex_incl_self_i,
  input  logic [PC_W-1:0]  ex_pc_i,
  input  logic             head_fault_i,
  input  logic             ctx_squash_i,
  input  logic             fetch_fault_i,
  input  logic             fetch_clear_i,
  input  logic             rob_empty_i,
  input  logic             rob_sq_done_i,
  input  logic             stores_pend_i,
  input  logic [SEQ_W-1:0] head_seq_i,
  input  logic [PC_W-1:0]  commit_pc_i,
  output logic             squash_o,
  output logic [SEQ_W-1:0] squash_seq_o,
  output logic [1:0]       squash_cause_o,
  output logic [PC_W-1:0]  redirect_pc_o,
  output logic             rob_squashing_o,
  output logic [1:0]       status_o
);

  sqc_status_e      status_q, status_d;
  logic             trap_req_q, trap_req_d;
  logic             ctx_pend_q, ctx_pend_d;
  logic             sq_q, sq_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  sqc_cause_e       cause_q, cause_d;
  logic [PC_W-1:0]  pc_q, pc_d;

  logic             ctx_any, sys_trap, sys_ctx, sys_serve;
  logic [SEQ_W-1:0] sys_bound;
  logic             ex_accept;
  logic [SEQ_W-1:0] ex_bound;
  logic             trap_start, trap_busy, trap_fire;
  logic             fetch_arm, fetch_cancel, fetch_busy, fetch_due;
  logic             fetch_take;

  // system flush selection: trap has precedence over context change
  always_comb begin
    ctx_any   = ctx_squash_i || ctx_pend_q;
    sys_trap  = trap_req_q;
    sys_ctx   = !trap_req_q && ctx_any;
    sys_serve = sys_trap || sys_ctx;
    if (rob_empty_i || (head_seq_i == '0)) sys_bound = '0;
    else                                   sys_bound = head_seq_i - SEQ_W'(1);
  end

  sqc_age_filter #(.SEQ_W(SEQ_W)) u_age (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_valid_i (ins_valid_i),
    .ins_seq_i   (ins_seq_i),
    .req_i       (ex_squash_i),
    .req_seq_i   (ex_seq_i),
    .incl_self_i (ex_incl_self_i),
    .block_i     ((status_q == ST_TRAP) || sys_serve),
    .clear_i     (sys_serve),
    .accept_o    (ex_accept),
    .bound_o     (ex_bound)
  );

  sqc_delay_timer #(.DLY(TRAP_DLY), .LEVEL(1'b0)) u_trap_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (trap_start),
    .cancel_i (1'b0),
    .busy_o   (trap_busy),
    .done_o   (trap_fire)
  );

  sqc_delay_timer #(.DLY(FETCH_DLY), .LEVEL(1'b1)) u_fetch_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (fetch_arm),
    .cancel_i (fetch_cancel),
    .busy_o   (fetch_busy),
    .done_o   (fetch_due)
  );

  // status next-state
  always_comb begin
    status_d   = status_q;
    trap_start = 1'b0;
    fetch_arm  = 1'b0;
    fetch_take = 1'b0;
    if (sys_serve || ex_accept) begin
      status_d = ST_ROB_SQ;
    end else begin
      unique case (status_q)
        ST_ROB_SQ: if (rob_sq_done_i) status_d = ST_RUNNING;
        ST_RUNNING: begin
          if (head_fault_i) begin
            status_d   = ST_TRAP;
            trap_start = 1'b1;
          end else if (fetch_fault_i && !fetch_clear_i) begin
            status_d  = ST_FETCH;
            fetch_arm = 1'b1;
          end
        end
        ST_FETCH: begin
          if (fetch_clear_i) begin
            status_d = ST_RUNNING;
          end else if (rob_empty_i && fetch_due && !stores_pend_i) begin
            status_d   = ST_TRAP;
            fetch_take = 1'b1;
          end else if (fetch_fault_i) begin
            fetch_arm = 1'b1;
          end
        end
        default: ;
      endcase
    end
    fetch_cancel = (status_q == ST_FETCH) && (status_d != ST_FETCH);
  end

  // pending requests
  always_comb begin
    trap_req_d = trap_fire || fetch_take;
    ctx_pend_d = trap_req_q && ctx_any;
  end

  // flush command
  always_comb begin
    sq_d    = sys_serve || ex_accept;
    seq_d   = seq_q;
    cause_d = cause_q;
    pc_d    = pc_q;
    if (sys_serve) begin
      seq_d   = sys_bound;
      cause_d = sys_trap ? CAUSE_TRAP : CAUSE_CTX;
      pc_d    = commit_pc_i;
    end else if (ex_accept) begin
      seq_d   = ex_bound;
      cause_d = CAUSE_EXEC;
      pc_d    = ex_pc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q   <= ST_RUNNING;
      trap_req_q <= 1'b0;
      ctx_pend_q <= 1'b0;
      sq_q       <= 1'b0;
    end else begin
      status_q   <= status_d;
      trap_req_q <= trap_req_d;
      ctx_pend_q <= ctx_pend_d;
      sq_q       <= sq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= '0;
      cause_q <= CAUSE_EXEC;
      pc_q    <= '0;
    end else if (sq_d) begin
      seq_q   <= seq_d;
      cause_q <= cause_d;
      pc_q    <= pc_d;
    end
  end

  assign squash_o        = sq_q;
  assign squash_seq_o    = seq_q;
  assign squash_cause_o  = cause_q;
  assign redirect_pc_o   = pc_q;
  assign rob_squashing_o = (status_q == ST_ROB_SQ);
  assign status_o        = status_q;

  // R6
  pulse_in_rob_sq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |-> (status_o == 2'd1) && rob_squashing_o);

  // R4
  trap_blocks_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == ST_TRAP && !trap_req_q && !ctx_squash_i && !ctx_pend_q) |=> !squash_o);

  // R1
  trap_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == ST_TRAP) |-> (trap_busy || trap_req_q || trap_fire));

  // R8
  fetch_take_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status_q == ST_TRAP) && $past(status_q == ST_FETCH))
      |-> ($past(rob_empty_i) && !$past(stores_pend_i)));

  // R7
  fetch_timer_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_busy |-> (status_q == ST_FETCH));

endmodule

// File: tb/squash_trap_ctrl_bench.sv
module squash_trap_ctrl_bench;
  localparam int SEQ_W = 16;
  localparam int PC_W  = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ins_valid_i, ex_squash_i, ex_incl_self_i, head_fault_i;
  logic             ctx_squash_i, fetch_fault_i, fetch_clear_i, rob_empty_i;
  logic             rob_sq_done_i, stores_pend_i;
  logic [SEQ_W-1:0] ins_seq_i, ex_seq_i, head_seq_i;
  logic [PC_W-1:0]  ex_pc_i, commit_pc_i;
  logic             squash_o, rob_squashing_o;
  logic [SEQ_W-1:0] squash_seq_o;
  logic [1:0]       squash_cause_o, status_o;
  logic [PC_W-1:0]  redirect_pc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  squash_trap_ctrl u_squash_trap_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ins_valid_i(ins_valid_i), .ins_seq_i(ins_seq_i),
    .ex_squash_i(ex_squash_i), .ex_seq_i(ex_seq_i),
    .ex_incl_self_i(ex_incl_self_i), .ex_pc_i(ex_pc_i),
    .head_fault_i(head_fault_i), .ctx_squash_i(ctx_squash_i),
    .fetch_fault_i(fetch_fault_i), .fetch_clear_i(fetch_clear_i),
    .rob_empty_i(rob_empty_i), .rob_sq_done_i(rob_sq_done_i),
    .stores_pend_i(stores_pend_i), .head_seq_i(head_seq_i),
    .commit_pc_i(commit_pc_i),
    .squash_o(squash_o), .squash_seq_o(squash_seq_o),
    .squash_cause_o(squash_cause_o), .redirect_pc_o(redirect_pc_o),
    .rob_squashing_o(rob_squashing_o), .status_o(status_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_squash();
    rob_sq_done_i = 1'b1;
    tick();
    rob_sq_done_i = 1'b0;
    chk(status_o, 0, "R6 back to Running");
  endtask

  task automatic t_reset();
    chk(status_o, 0, "R6 reset status");
    chk(squash_o, 0, "R6 reset squash");
    chk(rob_squashing_o, 0, "R6 reset robSquashing");
  endtask

  task automatic t_exec();
    ins_valid_i = 1'b1; ins_seq_i = 16'd20;
    tick();
    ins_valid_i = 1'b0;
    ex_squash_i = 1'b1; ex_seq_i = 16'd15; ex_incl_self_i = 1'b0; ex_pc_i = 32'h1000;
    tick();
    ex_squash_i = 1'b0;
    chk(squash_o, 1, "R6 exec pulse");
    chk(squash_seq_o, 15, "R5 exec boundary");
    chk(squash_cause_o, 0, "R6 exec cause");
    chk(redirect_pc_o, 32'h1000, "R5 exec redirect");
    chk(rob_squashing_o, 1, "R6 robSquashing");
    tick();
    chk(squash_o, 0, "R6 pulse one cycle");
    chk(status_o, 1, "R6 holds ROBSquashing");
    finish_squash();
    // youngest is now 15: a younger request is rejected
    ex_squash_i = 1'b1; ex_seq_i = 16'd16; ex_pc_i = 32'h1100;
    tick();
    ex_squash_i = 1'b0;
    chk(squash_o, 0, "R4 younger rejected");
    chk(status_o, 0, "R4 status unchanged");
    ex_squash_i = 1'b1; ex_seq_i = 16'd15; ex_incl_self_i = 1'b1; ex_pc_i = 32'h1200;
    tick();
    ex_squash_i = 1'b0; ex_incl_self_i = 1'b0;
    chk(squash_seq_o, 14, "R5 include-self");
    finish_squash();
    ex_squash_i = 1'b1; ex_seq_i = 16'd0; ex_incl_self_i = 1'b1;
    tick();
    ex_squash_i = 1'b0; ex_incl_self_i = 1'b0;
    chk(squash_o, 1, "R5 seq zero accepted");
    chk(squash_seq_o, 0, "R5 saturation at 0");
    finish_squash();
  endtask

  task automatic t_trap_ctx();
    ins_valid_i = 1'b1; ins_seq_i = 16'd60;
    tick();
    ins_valid_i = 1'b0;
    head_seq_i = 16'd50; rob_empty_i = 1'b0; commit_pc_i = 32'h2000;
    head_fault_i = 1'b1;
    tick();
    head_fault_i = 1'b0;
    chk(status_o, 2, "R1 TrapPending");
    for (int k = 1; k <= 6; k++) begin
      if (k == 1) begin ex_squash_i = 1'b1; ex_seq_i = 16'd10; end
      tick();
      ex_squash_i = 1'b0;
      if (squash_o !== 1'b0) chk(squash_o, 0, "R1/R4 early squash");
    end
    chk(status_o, 2, "R4 still TrapPending");
    ctx_squash_i = 1'b1;
    tick();
    ctx_squash_i = 1'b0;
    chk(squash_o, 1, "R1 trap at delay+1");
    chk(squash_cause_o, 1, "R2 trap first");
    chk(squash_seq_o, 49, "R3 head minus one");
    chk(redirect_pc_o, 32'h2000, "R3 redirect commit pc");
    rob_empty_i = 1'b1;
    tick();
    chk(squash_o, 1, "R2 context follows");
    chk(squash_cause_o, 2, "R2 context cause");
    chk(squash_seq_o, 0, "R3 empty boundary");
    tick();
    chk(squash_o, 0, "R6 no extra pulse");
    finish_squash();
    ex_squash_i = 1'b1; ex_seq_i = 16'd5;
    tick();
    ex_squash_i = 1'b0;
    chk(squash_o, 0, "R3 youngest reset rejects");
  endtask

  task automatic t_fetch();
    rob_empty_i = 1'b1; stores_pend_i = 1'b1;
    fetch_fault_i = 1'b1;
    tick();
    fetch_fault_i = 1'b0;
    chk(status_o, 3, "R7 FetchTrapPending");
    repeat (16) tick();
    chk(status_o, 3, "R8 stores hold fault");
    fetch_clear_i = 1'b1;
    tick();
    fetch_clear_i = 1'b0;
    chk(status_o, 0, "R7 clear returns Running");
    stores_pend_i = 1'b0;
    fetch_fault_i = 1'b1;
    tick();
    fetch_fault_i = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      tick();
      if (status_o !== 2'd3) chk(status_o, 3, "R8 before deadline");
    end
    chk(status_o, 3, "R8 waits deadline");
    tick();
    chk(status_o, 2, "R8 taken after deadline");
    chk(squash_o, 0, "R8 no pulse yet");
    tick();
    chk(squash_o, 1, "R8 trap pulse");
    chk(squash_cause_o, 1, "R8 trap cause");
    chk(squash_seq_o, 0, "R3 empty boundary fetch");
    finish_squash();
  endtask

  initial begin
    rst_n = 1'b0;
    ins_valid_i = 0; ins_seq_i = 0; ex_squash_i = 0; ex_seq_i = 0;
    ex_incl_self_i = 0; ex_pc_i = 0; head_fault_i = 0; ctx_squash_i = 0;
    fetch_fault_i = 0; fetch_clear_i = 0; rob_empty_i = 0; rob_sq_done_i = 0;
    stores_pend_i = 0; head_seq_i = 0; commit_pc_i = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_exec();
    t_trap_ctx();
    t_fetch();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule